// File: doc/BRIEF.md
# Key-Protected Command Sequence Table

This block is a register file of sixteen command sequences, each four 32-bit words long, that a serial-memory sequence engine reads to learn what to drive onto the flash bus. Each word holds two 16-bit instructions. The low half is the earlier instruction and the high half is the later one. An instruction has a 6-bit opcode in bits [15:10], a 2-bit lane code in bits [9:8] and an 8-bit operand in bits [7:0]. The opcodes are stop = 0, command = 1, address = 2 and read = 7.

Software changes the table through a simple write/read port made of a byte address, write data, a write strobe and combinational read data. A two-step handshake guards the table. First a magic key is written to the key register. Then the very next write must go to the lock-control register and carry the unlock or lock request. Table writes take effect only while the table is unlocked. A second, independent read port lets the engine fetch any word by sequence index and word index. That port has no effect on the register port.

Top module: `seq_table_regs`

## Requirements
- R1: After reset the table is locked, and `locked_o` is 1.
- R2: After reset, word 0 of sequence 0 holds 0x08180403: a command instruction with operand 0x03 in the low half and a 24-bit address instruction in the high half. Word 1 holds 0x00001C00: a read instruction in the low half and a stop in the high half. Every other word is zero.
- R3: A write of 0x5AF05AF0 to offset 0x300 arms the key. If the next write goes to offset 0x304 with bit 1 set and bit 0 clear, the table becomes unlocked.
- R4: If the key is armed and the next write goes to offset 0x304 with bit 0 set, the table becomes locked. When bits 0 and 1 are both set, the table locks.
- R5: The key is disarmed by any write other than the correct key to 0x300. This includes a wrong key value, a table write, a write to an unmapped offset and the lock-control write itself.
- R6: A lock-control write with the key not armed leaves the lock state unchanged.
- R7: Table writes made while the table is locked leave its contents unchanged.
- R8: While the table is unlocked, a write to 0x310 + n*16 + w*4 replaces word w of sequence n. The new word reads back at that offset and on the engine port.
- R9: A read of 0x304 returns the lock state in bit 0, with all other bits zero. A read of 0x300 returns zero.
- R10: The engine port returns the selected word combinationally, whatever the register port is addressing at the same time.
- R11: Writes to offsets outside the key, control and table ranges change no table word, and reads there return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 12 | Register byte offset |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write strobe, one write per cycle |
| rdata_o | output | 32 | Read data for addr_i |
| seq_sel_i | input | 4 | Engine sequence index |
| word_sel_i | input | 2 | Engine word index within the sequence |
| seq_word_o | output | 32 | Word fetched for the engine |
| locked_o | output | 1 | 1 when the table is locked |

## Verification
The stimulus targets the handshake's weak points:
- a lock-control write with no key in front of it;
- a wrong key value;
- a key separated from its command by a table write;
- a second command that reuses an already consumed key;
- a control word with both request bits set.

A design that remembered the key across other writes, or that resolved both bits toward unlock, would be left in the wrong lock state, and the status checks that follow would show it. Table writes are sent while locked, at the last table word and at the first offset past the table. A decoder with an off-by-one range, or a write enable that ignores the lock, would corrupt a word that the engine port then exposes. Engine reads are always paired with a register read of a different word in the same cycle, so crossed read paths are caught.

// File: rtl/qst_pkg.sv
package qst_pkg;
  localparam int unsigned DATA_W = 32;

  typedef enum logic [5:0] {
    OP_STOP = 6'd0,
    OP_CMD  = 6'd1,
    OP_ADDR = 6'd2,
    OP_READ = 6'd7
  } op_e;

  function automatic logic [15:0] mk_instr(op_e op, logic [1:0] lanes, logic [7:0] arg);
    return {op, lanes, arg};
  endfunction

  // reset image: sequence 0 = cmd 0x03, 24-bit address, read, stop
  function automatic logic [DATA_W-1:0] preset_word(int idx);
    case (idx)
      0:       return {mk_instr(OP_ADDR, 2'd0, 8'd24), mk_instr(OP_CMD, 2'd0, 8'h03)};
      1:       return {mk_instr(OP_STOP, 2'd0, 8'd0),  mk_instr(OP_READ, 2'd0, 8'd0)};
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/qst_decode.sv
module qst_decode #(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned TBL_WORDS = 64,
  parameter logic [ADDR_W-1:0] KEY_OFS = 12'h300,
  parameter logic [ADDR_W-1:0] LCK_OFS = 12'h304,
  parameter logic [ADDR_W-1:0] TBL_OFS = 12'h310,
  localparam int unsigned IDX_W = $clog2(TBL_WORDS)
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              key_hit_o,
  output logic              lck_hit_o,
  output logic              tbl_hit_o,
  output logic [IDX_W-1:0]  tbl_idx_o
);
  localparam int unsigned TBL_END = int'(TBL_OFS) + TBL_WORDS * 4;

  logic [ADDR_W-1:0] rel;

  assign rel       = addr_i - TBL_OFS;
  assign key_hit_o = (addr_i == KEY_OFS);
  assign lck_hit_o = (addr_i == LCK_OFS);
  assign tbl_hit_o = (addr_i >= TBL_OFS) && (int'(addr_i) < TBL_END);
  assign tbl_idx_o = rel[IDX_W+1:2];
endmodule

// File: rtl/qst_lock_ctrl.sv
module qst_lock_ctrl #(
  parameter logic [31:0] KEY_VAL = 32'h5AF0_5AF0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic        key_hit_i,
  input  logic        lck_hit_i,
  input  logic [31:0] wdata_i,
  output logic        locked_o
);
  logic armed_q, locked_q;
  logic cmd_ok;

  assign cmd_ok = we_i && lck_hit_i && armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q  <= 1'b0;
      locked_q <= 1'b1;
    end else begin
      // every write re-evaluates the key; only a correct key write arms it
      if (we_i) armed_q <= key_hit_i && (wdata_i == KEY_VAL);
      if (cmd_ok) begin
        if (wdata_i[0])      locked_q <= 1'b1;  // lock has priority
        else if (wdata_i[1]) locked_q <= 1'b0;
      end
    end
  end

  assign locked_o = locked_q;

  a_r3_unlock_needs_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(locked_q) |-> $past(armed_q && we_i && lck_hit_i && wdata_i[1] && !wdata_i[0]));

  a_r4_lock_needs_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_q) |-> $past(armed_q && we_i && lck_hit_i && wdata_i[0]));

  a_r5_disarm_on_other_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !key_hit_i) |=> !armed_q);

  a_r6_no_change_unarmed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q |=> $stable(locked_q));
endmodule

// File: rtl/qst_store.sv
module qst_store #(
  parameter int unsigned TBL_WORDS = 64,
  localparam int unsigned IDX_W = $clog2(TBL_WORDS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [IDX_W-1:0]          wr_idx_i,
  input  logic [31:0]               wdata_i,
  input  logic [IDX_W-1:0]          rd_a_idx_i,
  input  logic [IDX_W-1:0]          rd_b_idx_i,
  output logic [31:0]               rd_a_o,
  output logic [31:0]               rd_b_o,
  output logic [TBL_WORDS*32-1:0]   image_o
);
  for (genvar k = 0; k < TBL_WORDS; k++) begin : g_word
    logic [31:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 word_q <= qst_pkg::preset_word(k);
      else if (wr_en_i && (wr_idx_i == IDX_W'(k))) word_q <= wdata_i;
    end
    assign image_o[k*32 +: 32] = word_q;
  end

  assign rd_a_o = image_o[rd_a_idx_i*32 +: 32];
  assign rd_b_o = image_o[rd_b_idx_i*32 +: 32];
endmodule

// File: rtl/seq_table_regs.sv
module seq_table_regs #(
  parameter int unsigned NUM_SEQ   = 16,
  parameter int unsigned SEQ_WORDS = 4,
  parameter int unsigned ADDR_W    = 12,
  parameter logic [31:0] KEY_VAL   = 32'h5AF0_5AF0,
  localparam int unsigned SEQ_W     = $clog2(NUM_SEQ),
  localparam int unsigned WSEL_W    = $clog2(SEQ_WORDS),
  localparam int unsigned TBL_WORDS = NUM_SEQ * SEQ_WORDS,
  localparam int unsigned IDX_W     = $clog2(TBL_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic              we_i,
  output logic [31:0]       rdata_o,
  input  logic [SEQ_W-1:0]  seq_sel_i,
  input  logic [WSEL_W-1:0] word_sel_i,
  output logic [31:0]       seq_word_o,
  output logic              locked_o
);
  logic              key_hit, lck_hit, tbl_hit;
  logic [IDX_W-1:0]  tbl_idx, eng_idx;
  logic [31:0]       tbl_rd;
  logic [TBL_WORDS*32-1:0] image;

  qst_decode #(.ADDR_W(ADDR_W), .TBL_WORDS(TBL_WORDS)) u_dec (
    .addr_i(addr_i), .key_hit_o(key_hit), .lck_hit_o(lck_hit),
    .tbl_hit_o(tbl_hit), .tbl_idx_o(tbl_idx)
  );

  qst_lock_ctrl #(.KEY_VAL(KEY_VAL)) u_lock (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .key_hit_i(key_hit),
    .lck_hit_i(lck_hit), .wdata_i(wdata_i), .locked_o(locked_o)
  );

  assign eng_idx = IDX_W'(seq_sel_i) * IDX_W'(SEQ_WORDS) + IDX_W'(word_sel_i);

  qst_store #(.TBL_WORDS(TBL_WORDS)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(we_i && tbl_hit && !locked_o), .wr_idx_i(tbl_idx), .wdata_i(wdata_i),
    .rd_a_idx_i(tbl_idx), .rd_b_idx_i(eng_idx),
    .rd_a_o(tbl_rd), .rd_b_o(seq_word_o), .image_o(image)
  );

  always_comb begin
    rdata_o = '0;
    if (lck_hit)      rdata_o = {31'd0, locked_o};
    else if (tbl_hit) rdata_o = tbl_rd;
  end

  a_r7_frozen_while_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |=> $stable(image));

  a_r11_outside_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tbl_hit) |=> $stable(image));
endmodule

// File: tb/seq_table_regs_test.sv
module seq_table_regs_test;
  typedef struct {
    int          src;   // 0 register read, 1 engine port, 2 lock status
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic        clk = 0, rst_ni = 0, we_i = 0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [3:0]  seq_sel_i = '0;
  logic [1:0]  word_sel_i = '0;
  logic [31:0] rdata_o, seq_word_o;
  logic        locked_o;

  item_t sb[$];
  int    n_chk = 0, n_fail = 0;
  bit    done = 0;

  localparam logic [31:0] KEY = 32'h5AF0_5AF0;

  always #5 clk = ~clk;

  seq_table_regs uut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i), .we_i(we_i),
    .rdata_o(rdata_o), .seq_sel_i(seq_sel_i), .word_sel_i(word_sel_i),
    .seq_word_o(seq_word_o), .locked_o(locked_o)
  );

  // monitor: compares pending items away from the clock edge
  always @(posedge clk) begin
    #3;
    while (sb.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb.pop_front();
      act = (it.src == 0) ? rdata_o : (it.src == 1) ? seq_word_o : {31'd0, locked_o};
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s src=%0d actual=%08h expected=%08h", it.tag, it.src, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    addr_i = a; wdata_i = d; we_i = 1;
    @(negedge clk);
    we_i = 0;
  endtask

  // register read at a and engine read of (s,w) checked in the same cycle
  task automatic chk(input logic [11:0] a, input logic [31:0] ea,
                     input logic [3:0] s, input logic [1:0] w, input logic [31:0] ew,
                     input string tag);
    item_t it;
    addr_i = a; seq_sel_i = s; word_sel_i = w;
    it.src = 0; it.exp = ea; it.tag = tag; sb.push_back(it);
    it.src = 1; it.exp = ew; sb.push_back(it);
    @(negedge clk);
  endtask

  task automatic chk_lock(input logic exp, input string tag);
    item_t it;
    it.src = 2; it.exp = {31'd0, exp}; it.tag = tag; sb.push_back(it);
    @(negedge clk);
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);

    // R1 / R9: locked after reset, status readable
    chk_lock(1, "R1 reset locked");
    chk(12'h304, 32'h1, 4'd0, 2'd0, 32'h0818_0403, "R9 status read / R2 preset w0");
    // R2: preset image; R10 register and engine read different words
    chk(12'h310, 32'h0818_0403, 4'd0, 2'd1, 32'h0000_1C00, "R2 preset w1 / R10");
    chk(12'h318, 32'h0, 4'd0, 2'd2, 32'h0, "R2 preset w2");
    chk(12'h31C, 32'h0, 4'd5, 2'd3, 32'h0, "R2 other seq zero");

    // R7: table write while locked ignored
    wr(12'h320, 32'h0000_DEAD);
    chk(12'h320, 32'h0, 4'd1, 2'd0, 32'h0, "R7 locked write dropped");

    // R6: unlock without key
    wr(12'h304, 32'h2);
    chk_lock(1, "R6 unlock without key");
    // R5: wrong key value
    wr(12'h300, 32'h5AF0_5AF1); wr(12'h304, 32'h2);
    chk_lock(1, "R5 wrong key");
    // R5: table write between key and command
    wr(12'h300, KEY); wr(12'h330, 32'h1); wr(12'h304, 32'h2);
    chk_lock(1, "R5 intervening table write");
    // R5: unmapped write between key and command
    wr(12'h300, KEY); wr(12'h500, 32'h1); wr(12'h304, 32'h2);
    chk_lock(1, "R5 intervening unmapped write");

    // R3: proper unlock
    wr(12'h300, KEY); wr(12'h304, 32'h2);
    chk_lock(0, "R3 unlock with key");
    chk(12'h304, 32'h0, 4'd0, 2'd0, 32'h0818_0403, "R9 status unlocked");
    chk(12'h300, 32'h0, 4'd0, 2'd1, 32'h0000_1C00, "R9 key reads zero");

    // R8: writes while unlocked
    wr(12'h40C, 32'hCAFE_F00D);
    wr(12'h388, 32'h1234_5678);
    wr(12'h310, 32'h1111_2222);
    chk(12'h388, 32'h1234_5678, 4'd15, 2'd3, 32'hCAFE_F00D, "R8 last word / R10");
    chk(12'h40C, 32'hCAFE_F00D, 4'd7, 2'd2, 32'h1234_5678, "R8 seq7 w2");
    chk(12'h320, 32'h0, 4'd0, 2'd0, 32'h1111_2222, "R8 overwrite preset");

    // R11: just past the table, and the gap below it
    wr(12'h410, 32'hFFFF_FFFF);
    wr(12'h30C, 32'hFFFF_FFFF);
    chk(12'h410, 32'h0, 4'd15, 2'd3, 32'hCAFE_F00D, "R11 write past table");
    chk(12'h30C, 32'h0, 4'd0, 2'd0, 32'h1111_2222, "R11 gap read zero");

    // R6: lock without key while unlocked
    wr(12'h304, 32'h1);
    chk_lock(0, "R6 lock without key");
    // R4: lock with key, then R7 write ignored
    wr(12'h300, KEY); wr(12'h304, 32'h1);
    chk_lock(1, "R4 lock with key");
    wr(12'h388, 32'h0);
    chk(12'h388, 32'h1234_5678, 4'd7, 2'd2, 32'h1234_5678, "R7 write after relock");

    // R4: both bits set -> lock
    wr(12'h300, KEY); wr(12'h304, 32'h2);
    chk_lock(0, "R3 unlock again");
    wr(12'h300, KEY); wr(12'h304, 32'h3);
    chk_lock(1, "R4 both bits lock");

    // R5: command consumes the key
    wr(12'h300, KEY); wr(12'h304, 32'h2);
    wr(12'h304, 32'h1);
    chk_lock(0, "R5 key consumed by command");
    wr(12'h300, KEY); wr(12'h304, 32'h1);
    chk_lock(1, "R4 final lock");

    repeat (3) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      summary();
      $finish;
    end
  end
endmodule